// File: doc/BRIEF.md
# Systematic Reed-Solomon Stream Encoder

This block turns a stream of message symbols into Reed-Solomon codewords over GF(2^s). Each block of K input symbols leaves the encoder unchanged, and N-K parity symbols follow it. The parity is the remainder when the message polynomial, multiplied by x^(N-K), is divided by the generator polynomial. The generator is the product of the factors (x - α^(h·(r+i))) for i = 0 .. N-K-1. Here r is the first-root exponent and h is the scaling factor, which must be coprime with 2^s - 1.

Symbol width, field polynomial, N, K, first root and scaling factor are all fixed at elaboration. Both full-length codes (N = 2^s - 1) and shortened codes are supported. Symbols enter and leave through AXI4-Stream style valid/ready channels. A synchronous active-low reset and a clock enable apply to the whole block. The input TLAST is used only to raise two event pulses: one when TLAST is missing on the K-th symbol, and one when it appears on any other symbol. On the output side, TLAST marks the final parity symbol and a separate flag marks the last message symbol.

Top module: `rs_stream_encoder`

## Requirements
- R1: The first K output symbols of every codeword equal the K accepted input symbols, in the order they were accepted.
- R2: The last N-K output symbols of every codeword form the division remainder, highest-degree coefficient first. Every codeword, read with its first symbol as the highest-degree coefficient, evaluates to zero at each α^(h·(r+i)) for i = 0 .. N-K-1.
- R3: After the K-th symbol of a block is accepted, `s_tready` stays low until the last parity symbol of that block has been loaded into the output register.
- R4: `m_tlast` is high only with output symbol N-1 of a codeword (counting from 0), and `m_info` is high only with output symbol K-1.
- R5: While `m_tvalid` is high and the output is not taken, `m_tvalid`, `m_tdata`, `m_tlast` and `m_info` keep their values on the next cycle.
- R6: If the K-th symbol of a block is accepted with `s_tlast` low, `evt_tlast_missing` is high for the next enabled cycle; otherwise it is low.
- R7: If any symbol other than the K-th is accepted with `s_tlast` high, `evt_tlast_unexpected` is high for the next enabled cycle; otherwise it is low.
- R8: The value of `s_tlast` has no effect on block framing or on the symbols produced.
- R9: While `ce` is low, no transfer takes place on either channel (`s_tready` is low) and every output holds its value.
- R10: After reset, `m_tvalid` and both event flags are low, and `s_tready` is high when `ce` is high.
- R11: With `ce` and `m_tready` held high and input always valid, one codeword completes every N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low, held for at least 2 cycles |
| ce | input | 1 | Clock enable; qualifies all state changes and both handshakes |
| s_tvalid | input | 1 | Input symbol valid |
| s_tready | output | 1 | Encoder can take a message symbol |
| s_tdata | input | SYM_W | Input message symbol |
| s_tlast | input | 1 | Sender's end-of-message mark, used only for event flags |
| m_tvalid | output | 1 | Output symbol valid |
| m_tready | input | 1 | Downstream can take a symbol |
| m_tdata | output | SYM_W | Output codeword symbol |
| m_tlast | output | 1 | Final parity symbol of the codeword |
| m_info | output | 1 | Last message symbol of the codeword |
| evt_tlast_missing | output | 1 | Pulse: K-th symbol was accepted without TLAST |
| evt_tlast_unexpected | output | 1 | Pulse: TLAST was seen on a symbol other than the K-th |

## Verification
The assertions check the following on every cycle:
- `m_info` and `m_tlast` fall at the right codeword positions.
- Held output stays stable under back-pressure, and everything freezes while the enable is low.
- `s_tready` stays low while parity is still to be loaded.
- Each event pulse is traced back to an accepted symbol with the matching TLAST condition.

The parity values themselves, the zeros at the generator roots, the pass-through of message symbols, and the N-cycle throughput can only be shown by the bench's scenarios. These are compared against a polynomial long-division model under steady streaming, random stalls and gaps, wrong TLAST placement, and a directed stretch with the clock enable held low.

// File: rtl/rs_enc_pkg.sv
// Package: shared types and elaboration-time Galois-field helpers for the
// Reed-Solomon encoder. The functions work on plain integers and are meant
// to be called only in constant expressions (generator tap values).
package rs_enc_pkg;

    typedef enum logic {
        PH_DATA   = 1'b0,
        PH_PARITY = 1'b1
    } rs_phase_e;

    localparam int MAX_PAR = 256;

    // Product of two field elements, shift-and-add with modular reduction.
    function automatic int gf_mul_int(int a, int b, int w, int poly);
        int acc = 0;
        int x = a;
        for (int i = 0; i < w; i++) begin
            if (((b >> i) & 1) != 0) acc = acc ^ x;
            x = x << 1;
            if (((x >> w) & 1) != 0) x = x ^ poly;
        end
        return acc;
    endfunction

    // alpha raised to e, where alpha is the element x (value 2).
    function automatic int gf_pow_int(int e, int w, int poly);
        int r = 1;
        int b = 2;
        int k = e;
        while (k > 0) begin
            if ((k & 1) != 0) r = gf_mul_int(r, b, w, poly);
            b = gf_mul_int(b, b, w, poly);
            k = k >> 1;
        end
        return r;
    endfunction

    // Coefficient of x^idx in the product of nr root factors.
    function automatic int gen_coef(int idx, int nr, int w, int poly,
                                    int start, int scale);
        int g [0:MAX_PAR];
        int root;
        for (int j = 0; j <= MAX_PAR; j++) g[j] = 0;
        g[0] = 1;
        for (int i = 0; i < nr; i++) begin
            root = gf_pow_int((scale * (start + i)) % ((1 << w) - 1), w, poly);
            for (int j = i + 1; j >= 1; j--)
                g[j] = g[j-1] ^ gf_mul_int(g[j], root, w, poly);
            g[0] = gf_mul_int(g[0], root, w, poly);
        end
        return g[idx];
    endfunction

endpackage

// File: rtl/rs_gf_cmul.sv
// Module: multiplier of a variable field element by a constant.
// Assumes FIELD_POLY includes the x^SYM_W term; only its low SYM_W bits
// are used for reduction. The result is a pure XOR network.
module rs_gf_cmul #(
    parameter int SYM_W      = 8,
    parameter int FIELD_POLY = 285,
    parameter int COEF       = 1
) (
    input  logic [SYM_W-1:0] a,
    output logic [SYM_W-1:0] y
);

    localparam logic [SYM_W-1:0] RED   = SYM_W'(FIELD_POLY);
    localparam logic [SYM_W-1:0] CBITS = SYM_W'(COEF);

    logic [SYM_W-1:0] pw [SYM_W];

    assign pw[0] = a;

    // Successive products a*x^j, each reduced by the field polynomial.
    generate
        for (genvar j = 1; j < SYM_W; j++) begin : g_xtime
            assign pw[j] = {pw[j-1][SYM_W-2:0], 1'b0}
                         ^ ({SYM_W{pw[j-1][SYM_W-1]}} & RED);
        end
    endgenerate

    // Sum the powers selected by the constant's bits.
    always_comb begin
        y = '0;
        for (int j = 0; j < SYM_W; j++)
            if (CBITS[j]) y = y ^ pw[j];
    end

endmodule

// File: rtl/rs_parity_lfsr.sv
// Module: parity division register. On absorb, the feedback is
// (din + top stage), multiplied into every tap. On drain, the feedback is
// forced to zero, so the stages shift toward the top and fill with zero.
// After NPAR drain steps the register is clear for the next block.
// Assumes the generator is monic; taps 0..NPAR-1 are its lower coefficients.
module rs_parity_lfsr #(
    parameter int SYM_W      = 8,
    parameter int FIELD_POLY = 285,
    parameter int NPAR       = 16,
    parameter int GEN_START  = 0,
    parameter int GEN_SCALE  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             absorb,
    input  logic             drain,
    input  logic [SYM_W-1:0] din,
    output logic [SYM_W-1:0] par_top
);

    logic [SYM_W-1:0] par_q [NPAR];
    logic [SYM_W-1:0] prod  [NPAR];
    logic [SYM_W-1:0] fb;

    assign fb      = absorb ? (din ^ par_q[NPAR-1]) : '0;
    assign par_top = par_q[NPAR-1];

    // One constant multiplier per generator tap.
    generate
        for (genvar gi = 0; gi < NPAR; gi++) begin : g_tap
            localparam int COEF = rs_enc_pkg::gen_coef(gi, NPAR, SYM_W,
                                      FIELD_POLY, GEN_START, GEN_SCALE);
            rs_gf_cmul #(
                .SYM_W     (SYM_W),
                .FIELD_POLY(FIELD_POLY),
                .COEF      (COEF)
            ) u_mul (
                .a(fb),
                .y(prod[gi])
            );
        end
    endgenerate

    // Division step on absorb, zero-feedback shift on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPAR; i++) par_q[i] <= '0;
        end else if (ce && (absorb || drain)) begin
            par_q[0] <= prod[0];
            for (int i = 1; i < NPAR; i++) par_q[i] <= par_q[i-1] ^ prod[i];
        end
    end

endmodule

// File: rtl/rs_enc_ctrl.sv
// Module: block sequencer. Counts K message symbols, then NPAR parity
// emissions, and owns the input ready, the position marks and the TLAST
// event pulses. Assumes out_space means the output register can take a
// symbol this cycle. All state advances only while ce is high.
module rs_enc_ctrl #(
    parameter int K    = 188,
    parameter int NPAR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic s_tvalid,
    input  logic s_tlast,
    input  logic out_space,
    output logic s_tready,
    output logic absorb,
    output logic drain,
    output logic mark_info,
    output logic mark_last,
    output logic evt_missing,
    output logic evt_unexpected
);

    import rs_enc_pkg::*;

    localparam int DCW = (K > 1) ? $clog2(K) : 1;
    localparam int PCW = $clog2(NPAR);
    localparam logic [DCW-1:0] D_LAST = DCW'(K - 1);
    localparam logic [PCW-1:0] P_LAST = PCW'(NPAR - 1);

    rs_phase_e      phase_q;
    logic [DCW-1:0] dcnt_q;
    logic [PCW-1:0] pcnt_q;
    logic           at_kth;

    assign at_kth    = (dcnt_q == D_LAST);
    assign s_tready  = ce && (phase_q == PH_DATA) && out_space;
    assign absorb    = s_tvalid && s_tready;
    assign drain     = ce && (phase_q == PH_PARITY) && out_space;
    assign mark_info = absorb && at_kth;
    assign mark_last = drain && (pcnt_q == P_LAST);

    // Phase and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DATA;
            dcnt_q  <= '0;
            pcnt_q  <= '0;
        end else if (absorb) begin
            if (at_kth) begin
                dcnt_q  <= '0;
                phase_q <= PH_PARITY;
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end else if (drain) begin
            if (pcnt_q == P_LAST) begin
                pcnt_q  <= '0;
                phase_q <= PH_DATA;
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // Event pulses, recomputed on every enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_missing    <= 1'b0;
            evt_unexpected <= 1'b0;
        end else if (ce) begin
            evt_missing    <= absorb && at_kth && !s_tlast;
            evt_unexpected <= absorb && !at_kth && s_tlast;
        end
    end

endmodule

// File: rtl/rs_enc_outreg.sv
// Module: single output register with valid/ready. Takes either a message
// symbol or a parity symbol, with its marks. Assumes the two load strobes
// are never high together and are only raised while space is high.
module rs_enc_outreg #(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             load_data,
    input  logic             load_par,
    input  logic [SYM_W-1:0] din,
    input  logic [SYM_W-1:0] par,
    input  logic             info_in,
    input  logic             last_in,
    input  logic             m_tready,
    output logic             m_tvalid,
    output logic [SYM_W-1:0] m_tdata,
    output logic             m_tlast,
    output logic             m_info,
    output logic             space
);

    assign space = !m_tvalid || m_tready;

    // Load a new symbol or drop valid once the symbol is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_tvalid <= 1'b0;
            m_tdata  <= '0;
            m_tlast  <= 1'b0;
            m_info   <= 1'b0;
        end else if (ce) begin
            if (load_data || load_par) begin
                m_tvalid <= 1'b1;
                m_tdata  <= load_par ? par : din;
                m_tlast  <= last_in;
                m_info   <= info_in;
            end else if (m_tready) begin
                m_tvalid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rs_stream_encoder.sv
// Module: top of the systematic Reed-Solomon stream encoder. It ties the
// sequencer, the parity divider and the output register together.
// Assumes 3 <= N <= 2^SYM_W - 1, max(N-256,1) <= K <= N-2, FIELD_POLY
// primitive of degree SYM_W, and GEN_SCALE coprime with 2^SYM_W - 1.
module rs_stream_encoder #(
    parameter int SYM_W      = 8,
    parameter int FIELD_POLY = 285,
    parameter int N          = 204,
    parameter int K          = 188,
    parameter int GEN_START  = 0,
    parameter int GEN_SCALE  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             s_tvalid,
    output logic             s_tready,
    input  logic [SYM_W-1:0] s_tdata,
    input  logic             s_tlast,
    output logic             m_tvalid,
    input  logic             m_tready,
    output logic [SYM_W-1:0] m_tdata,
    output logic             m_tlast,
    output logic             m_info,
    output logic             evt_tlast_missing,
    output logic             evt_tlast_unexpected
);

    localparam int NPAR = N - K;

    logic             absorb;
    logic             drain;
    logic             mark_info;
    logic             mark_last;
    logic             out_space;
    logic [SYM_W-1:0] par_top;

    rs_enc_ctrl #(
        .K   (K),
        .NPAR(NPAR)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce            (ce),
        .s_tvalid      (s_tvalid),
        .s_tlast       (s_tlast),
        .out_space     (out_space),
        .s_tready      (s_tready),
        .absorb        (absorb),
        .drain         (drain),
        .mark_info     (mark_info),
        .mark_last     (mark_last),
        .evt_missing   (evt_tlast_missing),
        .evt_unexpected(evt_tlast_unexpected)
    );

    rs_parity_lfsr #(
        .SYM_W     (SYM_W),
        .FIELD_POLY(FIELD_POLY),
        .NPAR      (NPAR),
        .GEN_START (GEN_START),
        .GEN_SCALE (GEN_SCALE)
    ) u_lfsr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce     (ce),
        .absorb (absorb),
        .drain  (drain),
        .din    (s_tdata),
        .par_top(par_top)
    );

    rs_enc_outreg #(
        .SYM_W(SYM_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .load_data(absorb),
        .load_par (drain),
        .din      (s_tdata),
        .par      (par_top),
        .info_in  (mark_info),
        .last_in  (mark_last),
        .m_tready (m_tready),
        .m_tvalid (m_tvalid),
        .m_tdata  (m_tdata),
        .m_tlast  (m_tlast),
        .m_info   (m_info),
        .space    (out_space)
    );

endmodule

// File: rtl/rs_stream_encoder_chk.sv
// Module: property checker bound to the encoder top. It tracks the output
// position within a codeword from the output handshake alone.
module rs_stream_encoder_chk #(
    parameter int SYM_W = 8,
    parameter int N     = 204,
    parameter int K     = 188
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             s_tvalid,
    input logic             s_tready,
    input logic             s_tlast,
    input logic             m_tvalid,
    input logic             m_tready,
    input logic [SYM_W-1:0] m_tdata,
    input logic             m_tlast,
    input logic             m_info,
    input logic             evt_tlast_missing,
    input logic             evt_tlast_unexpected
);

    localparam int OW = $clog2(N);

    logic [OW-1:0] out_idx;

    // Position of the symbol now on the output within its codeword.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_idx <= '0;
        else if (ce && m_tvalid && m_tready)
            out_idx <= (out_idx == OW'(N - 1)) ? '0 : out_idx + 1'b1;
    end

    assert_info_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_info == (out_idx == OW'(K - 1))));

    assert_last_position_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tlast == (out_idx == OW'(N - 1))));

    assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !(m_tready && ce)) |=>
            (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_info)));

    assert_no_input_in_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && out_idx >= OW'(K) && out_idx < OW'(N - 1)) |-> !s_tready);

    assert_missing_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tlast_missing && $past(ce)) |-> $past(s_tvalid && s_tready && !s_tlast));

    assert_unexpected_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tlast_unexpected && $past(ce)) |-> $past(s_tvalid && s_tready && s_tlast));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(m_tvalid) && $stable(m_tdata) && $stable(m_tlast) &&
                 $stable(m_info) && $stable(evt_tlast_missing) &&
                 $stable(evt_tlast_unexpected)));

    assert_idle_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!m_tvalid && !evt_tlast_missing && !evt_tlast_unexpected));

endmodule

bind rs_stream_encoder rs_stream_encoder_chk #(
    .SYM_W(SYM_W),
    .N    (N),
    .K    (K)
) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .ce                  (ce),
    .s_tvalid            (s_tvalid),
    .s_tready            (s_tready),
    .s_tlast             (s_tlast),
    .m_tvalid            (m_tvalid),
    .m_tready            (m_tready),
    .m_tdata             (m_tdata),
    .m_tlast             (m_tlast),
    .m_info              (m_info),
    .evt_tlast_missing   (evt_tlast_missing),
    .evt_tlast_unexpected(evt_tlast_unexpected)
);

// File: tb/rs_stream_encoder_tb.sv
module rs_stream_encoder_tb;

    localparam int SW    = 8;
    localparam int POLY  = 285;
    localparam int NN    = 204;
    localparam int KK    = 188;
    localparam int RR    = NN - KK;
    localparam int START = 0;
    localparam int SCALE = 1;
    localparam int QMAX  = (1 << SW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce = 1'b1;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic [SW-1:0] s_tdata = '0;
    logic          s_tlast = 1'b0;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic [SW-1:0] m_tdata;
    logic          m_tlast;
    logic          m_info;
    logic          evt_tlast_missing;
    logic          evt_tlast_unexpected;

    rs_stream_encoder #(
        .SYM_W(SW), .FIELD_POLY(POLY), .N(NN), .K(KK),
        .GEN_START(START), .GEN_SCALE(SCALE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .m_info(m_info),
        .evt_tlast_missing(evt_tlast_missing), .evt_tlast_unexpected(evt_tlast_unexpected)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    bit run     = 0;
    bit fast    = 0;
    int mode    = 0;  // 0: enable and ready high, 1: random, 2: directed

    int gen   [0:RR];
    int roots [0:RR-1];
    int expq [$];
    int rx   [0:NN-1];
    int rx_idx = 0;
    int in_cnt = 0;
    int blocks_in = 0;
    int out_total = 0;
    int cyc = 0;
    int prev_last_cyc = -1;
    bit exp_miss = 0, exp_unexp = 0;
    int seen_miss = 0, seen_unexp = 0;
    bit held_v = 0;
    int held_d = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int bmul(int a, int b);
        int r = 0;
        for (int i = 0; i < SW; i++) begin
            if ((b & 1) != 0) r ^= a;
            b = b >> 1;
            a = a << 1;
            if ((a & (1 << SW)) != 0) a ^= POLY;
        end
        return r;
    endfunction

    function automatic int bpow(int e);
        int r = 1;
        for (int i = 0; i < e; i++) r = bmul(r, 2);
        return r;
    endfunction

    // Generator built by expanding the root factors one at a time.
    task automatic build_gen();
        int nxt [0:RR];
        for (int j = 0; j <= RR; j++) gen[j] = 0;
        gen[0] = 1;
        for (int i = 0; i < RR; i++) begin
            roots[i] = bpow((SCALE * (START + i)) % QMAX);
            for (int j = 0; j <= RR; j++)
                nxt[j] = bmul(gen[j], roots[i]) ^ ((j > 0) ? gen[j-1] : 0);
            for (int j = 0; j <= RR; j++) gen[j] = nxt[j];
        end
    endtask

    // Hold one symbol until the encoder takes it.
    task automatic push_sym(input int d, input bit l, input bit gappy);
        bit acc;
        if (gappy && ($urandom % 4 == 0)) begin
            s_tvalid = 1'b0;
            @(posedge clk); #2;
        end
        s_tvalid = 1'b1;
        s_tdata  = SW'(d);
        s_tlast  = l;
        do begin
            @(negedge clk);
            acc = s_tvalid && s_tready;
            @(posedge clk); #2;
        end while (!acc);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    // One message block: model codeword by long division, then stream it.
    task automatic send_block(input int unexp_pos, input bit drop_last, input bit gappy);
        int msg [0:KK-1];
        int w   [0:NN-1];
        int c;
        for (int i = 0; i < NN; i++) w[i] = 0;
        for (int i = 0; i < KK; i++) begin
            msg[i] = $urandom % (QMAX + 1);
            w[i] = msg[i];
        end
        for (int i = 0; i < KK; i++) begin
            c = w[i];
            if (c != 0)
                for (int j = 1; j <= RR; j++) w[i+j] ^= bmul(c, gen[RR-j]);
        end
        for (int i = 0; i < KK; i++)
            expq.push_back(msg[i] | ((i == KK-1) ? (1 << 17) : 0));
        for (int j = 0; j < RR; j++)
            expq.push_back(w[KK+j] | ((j == RR-1) ? (1 << 16) : 0));
        for (int i = 0; i < KK; i++)
            push_sym(msg[i], ((i == KK-1) && !drop_last) || (i == unexp_pos), gappy);
    endtask

    // Enable and downstream-ready pattern.
    initial begin
        forever begin
            @(posedge clk); #2;
            if (mode == 0) begin
                ce = 1'b1; m_tready = 1'b1;
            end else if (mode == 1) begin
                ce = ($urandom % 5 != 0);
                m_tready = ($urandom % 3 != 0);
            end
        end
    end

    // Cycle monitor: events, input pacing, output symbols against the model.
    always @(negedge clk) begin
        if (run) begin
            int e, acc, ev;
            cyc++;
            chk(evt_tlast_missing == exp_miss, "R6", "missing flag", evt_tlast_missing, exp_miss);
            chk(evt_tlast_unexpected == exp_unexp, "R7", "unexpected flag", evt_tlast_unexpected, exp_unexp);
            if (evt_tlast_missing && ce) seen_miss++;
            if (evt_tlast_unexpected && ce) seen_unexp++;
            if (held_v)
                chk(m_tvalid && int'(m_tdata) == held_d, "R5", "held symbol", int'(m_tdata), held_d);
            acc = s_tvalid && s_tready;
            if (ce) begin
                exp_miss  = acc && (in_cnt == KK-1) && !s_tlast;
                exp_unexp = acc && (in_cnt != KK-1) && s_tlast;
            end
            if (s_tready && in_cnt == 0)
                chk(out_total >= blocks_in * NN - 1, "R3", "ready before parity done",
                    out_total, blocks_in * NN - 1);
            if (acc) begin
                in_cnt++;
                if (in_cnt == KK) begin in_cnt = 0; blocks_in++; end
            end
            held_v = m_tvalid && !(m_tready && ce);
            held_d = int'(m_tdata);
            if (ce && m_tvalid && m_tready) begin
                if (expq.size() == 0) begin
                    chk(0, "R1", "unexpected output symbol", int'(m_tdata), -1);
                end else begin
                    e = expq.pop_front();
                    chk(int'(m_tdata) == (e & 16'hffff), (rx_idx < KK) ? "R1" : "R2",
                        "symbol value", int'(m_tdata), e & 16'hffff);
                    chk(m_tlast == e[16], "R4", "tlast position", m_tlast, e[16]);
                    chk(m_info == e[17], "R4", "info position", m_info, e[17]);
                end
                rx[rx_idx] = int'(m_tdata);
                out_total++;
                if (m_tlast) begin
                    chk(rx_idx == NN-1, "R4", "codeword length", rx_idx + 1, NN);
                    for (int r = 0; r < RR; r++) begin
                        ev = 0;
                        for (int i = 0; i < NN; i++) ev = bmul(ev, roots[r]) ^ rx[i];
                        chk(ev == 0, "R2", "codeword at generator root", ev, 0);
                    end
                    if (fast && prev_last_cyc >= 0)
                        chk(cyc - prev_last_cyc == NN, "R11", "cycles per codeword",
                            cyc - prev_last_cyc, NN);
                    prev_last_cyc = cyc;
                    rx_idx = 0;
                end else if (rx_idx < NN-1) begin
                    rx_idx++;
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int d0, v0;
        build_gen();
        // R10: reset state
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(m_tvalid == 1'b0, "R10", "valid after reset", m_tvalid, 0);
        chk(s_tready == 1'b1, "R10", "ready after reset", s_tready, 1);
        chk(!evt_tlast_missing && !evt_tlast_unexpected, "R10", "events after reset",
            evt_tlast_missing | evt_tlast_unexpected, 0);
        @(posedge clk); #2;
        run = 1;

        // R11, R1, R2: back-to-back blocks at full rate
        fast = 1;
        prev_last_cyc = -1;
        for (int b = 0; b < 3; b++) send_block(-1, 0, 0);
        repeat (NN) @(posedge clk);
        fast = 0;

        // R1, R2, R5: random stalls, gaps and enable drops
        mode = 1;
        #0;
        for (int b = 0; b < 12; b++) send_block(-1, 0, 1);

        // R6, R7, R8: misplaced or missing TLAST, framing unchanged
        mode = 0;
        send_block(5, 0, 0);
        send_block(-1, 1, 0);
        send_block(0, 1, 1);
        send_block(KK-2, 0, 0);
        repeat (NN + 4) @(posedge clk); #2;
        chk(seen_miss == 2, "R6", "missing pulses", seen_miss, 2);
        chk(seen_unexp == 3, "R7", "unexpected pulses", seen_unexp, 3);

        // R9: enable low freezes outputs and blocks input
        mode = 2;
        ce = 1'b1; m_tready = 1'b1;
        fork
            send_block(-1, 0, 0);
            begin
                repeat (30) @(posedge clk);
                #2 ce = 1'b0;
                @(negedge clk);
                d0 = int'(m_tdata);
                v0 = int'(m_tvalid);
                for (int i = 0; i < 4; i++) begin
                    @(negedge clk);
                    chk(int'(m_tdata) == d0 && int'(m_tvalid) == v0, "R9",
                        "output frozen", int'(m_tdata), d0);
                    chk(s_tready == 1'b0, "R9", "ready while disabled", s_tready, 0);
                end
                @(posedge clk); #2 ce = 1'b1;
            end
        join
        mode = 0;

        for (int i = 0; i < 4000 && expq.size() != 0; i++) @(posedge clk);
        chk(expq.size() == 0, "R1", "all codeword symbols delivered", expq.size(), 0);
        repeat (4) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule